// File: doc/BRIEF.md
# Core clock source selection controller

This block forms the enable that clocks a small processor core. Everything runs on one fast reference clock. The crystal, the alternate clock and the multiplier output are all modelled as single-cycle enable pulses on that clock. A crystal pulse can be halved. It then goes either straight through, through a fixed divide-by-16 stage, or through a rate multiplier that scales its rate by M/N. An alternate clock, when one is present, can take the place of the whole crystal chain.

Four byte-wide registers on a simple write/read bus hold the configuration. When the core enters wait-for-interrupt, the block can switch to the alternate clock and raise a low-power request by itself. It can also stop the crystal oscillator while the alternate clock is running. When the wait ends, all of these automatic changes are undone. Every change of source is made without glitches: the old source is released on one of its own pulses, and the new source is passed through only after two of its pulses have been counted.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset all four registers read zero, `int_tick` is low, `xt_osc_en` is high, `low_power` and `ckaf_status` are low, and the active source is the direct crystal path.
- R2: Bit 0 of the mode register (address 0) set makes the crystal chain use only every second `xt_tick` pulse, starting with the second one after reset.
- R3: Bit 1 of the select register (address 1) set makes the non-multiplied path pass only every sixteenth pulse of the (possibly halved) crystal chain.
- R4: Bit 0 of the select register chooses the multiplied path. Its pulse rate is the chain rate times M (field bits 1:0 of address 3: 00 gives 6, 01 gives 8, 10 gives 10, 11 gives 14) divided by N = 1 + bits 4:2 of address 3. The rate is capped at one pulse per reference cycle, with a saturating backlog.
- R5: Bit 0 of the control register (address 2) selects the alternate clock, but only while `af_present` is high. `ckaf_status` and bit 7 of address 1 report whether the alternate clock is the active, running source.
- R6: A source change suppresses `int_tick` from the first cycle after the change is requested. The old source is released on its next pulse, or at once if it is the alternate clock and that clock has vanished. The new source drives `int_tick` only after two of its own pulses.
- R7: Bit 2 of the select register drops `xt_osc_en` only while the alternate clock is present, active and running.
- R8: Bit 1 of the control register makes `low_power` follow `wfi_active`, one cycle later.
- R9: Bit 2 of the control register makes the block select the alternate clock during wait-for-interrupt, but only if `af_present` is high.
- R10: When `wfi_active` falls, the automatic alternate-clock and low-power selections are withdrawn, the register-selected source is restored through R6, and the crystal is re-enabled.
- R11: The registers read back one cycle after the address is presented. Address 0 and address 3 keep all 8 written bits, address 2 keeps all 8 bits, and address 1 keeps bits 5:0 with bit 6 reporting `af_present` and bit 7 the alternate-clock status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| xt_tick | input | 1 | Crystal oscillator pulse |
| af_tick | input | 1 | Alternate clock pulse |
| af_present | input | 1 | Alternate clock available |
| wfi_active | input | 1 | Core is in wait-for-interrupt |
| int_tick | output | 1 | Internal clock enable to the core |
| xt_osc_en | output | 1 | Crystal oscillator enable |
| low_power | output | 1 | Low-power operation request |
| ckaf_status | output | 1 | Alternate clock is the running source |

## Verification
The hardest situation to reach is the return from a wait-for-interrupt that had stopped the crystal. When the core wakes, the alternate clock must be released, the crystal restarted, and the multiplied path allowed to build up pulses again before the two-pulse handover can finish. The stimulus reaches this state by turning on the crystal stop and the automatic wait behaviours, entering wait with the alternate clock present, and then dropping `wfi_active`. The bench's crystal generator honours `xt_osc_en`, so it genuinely goes quiet while stopped and resumes only when re-enabled. A separate case removes `af_present` while the alternate clock is running, to exercise release of a source that has vanished.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_MODE = 2'd0;
  localparam logic [REG_AW-1:0] A_SEL  = 2'd1;
  localparam logic [REG_AW-1:0] A_CTL  = 2'd2;
  localparam logic [REG_AW-1:0] A_PLL  = 2'd3;

  typedef enum logic [1:0] {SRC_XT = 2'd0, SRC_PLL = 2'd1, SRC_ALT = 2'd2} src_e;
  typedef enum logic [1:0] {SW_RUN = 2'd0, SW_DRAIN = 2'd1, SW_SYNC = 2'd2} sw_e;

  function automatic logic [3:0] mult_of(input logic [1:0] mx);
    case (mx)
      2'd0:    mult_of = 4'd6;
      2'd1:    mult_of = 4'd8;
      2'd2:    mult_of = 4'd10;
      default: mult_of = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/clksrc_regs.sv
module clksrc_regs
  import clksrc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              alt_running,
  input  logic              af_present,
  output logic              half_sel,
  output logic              pll_sel,
  output logic              div16_sel,
  output logic              xt_stop,
  output logic              alt_sel,
  output logic              lp_wfi,
  output logic              alt_wfi,
  output logic [1:0]        mx,
  output logic [2:0]        dx,
  output logic [DW-1:0]     rdata
);
  localparam int SEL_W = DW - 2;

  logic [DW-1:0]    mode_q, ctl_q, pll_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      sel_q  <= '0;
      ctl_q  <= '0;
      pll_q  <= '0;
      rdata  <= '0;
    end else begin
      case (addr)
        A_MODE:  rdata <= mode_q;
        A_SEL:   rdata <= {alt_running, af_present, sel_q};
        A_CTL:   rdata <= ctl_q;
        default: rdata <= pll_q;
      endcase
      if (we) begin
        case (addr)
          A_MODE:  mode_q <= wdata;
          A_SEL:   sel_q  <= wdata[SEL_W-1:0];
          A_CTL:   ctl_q  <= wdata;
          default: pll_q  <= wdata;
        endcase
      end
    end
  end

  assign half_sel  = mode_q[0];
  assign pll_sel   = sel_q[0];
  assign div16_sel = sel_q[1];
  assign xt_stop   = sel_q[2];
  assign alt_sel   = ctl_q[0];
  assign lp_wfi    = ctl_q[1];
  assign alt_wfi   = ctl_q[2];
  assign mx        = pll_q[1:0];
  assign dx        = pll_q[4:2];

  assert_pll_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(pll_q));
  assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (we && addr != A_CTL) |=> $stable(ctl_q));
endmodule

// File: rtl/clksrc_paths.sv
module clksrc_paths
  import clksrc_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xt_tick,
  input  logic       half_sel,
  input  logic       div16_sel,
  input  logic [1:0] mx,
  input  logic [2:0] dx,
  output logic       np_tick,
  output logic       pll_tick
);
  localparam logic [ACC_W:0] ACC_MAX = (ACC_W+1)'((1 << ACC_W) - 1);

  logic             half_ph_q;
  logic [DIV_W-1:0] div_q;
  logic [ACC_W-1:0] acc_q;
  logic             base_tick;
  logic [3:0]       mult, nfac;
  logic [ACC_W:0]   sum;

  assign base_tick = xt_tick && (!half_sel || half_ph_q);
  assign np_tick   = base_tick && (!div16_sel || (&div_q));
  assign mult      = mult_of(mx);
  assign nfac      = {1'b0, dx} + 4'd1;
  assign pll_tick  = acc_q >= ACC_W'(nfac);

  always_comb begin
    sum = {1'b0, acc_q};
    if (base_tick) sum = sum + (ACC_W+1)'(mult);
    if (pll_tick)  sum = sum - (ACC_W+1)'(nfac);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_ph_q <= 1'b0;
      div_q     <= '0;
      acc_q     <= '0;
    end else begin
      if (xt_tick)   half_ph_q <= ~half_ph_q;
      if (base_tick) div_q <= div_q + 1'b1;
      acc_q <= (sum > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum[ACC_W-1:0];
    end
  end

  assert_np_needs_crystal_R3: assert property (@(posedge clk) disable iff (rst)
    (np_tick && div16_sel) |-> ($past(div_q) == DIV_W'((1 << DIV_W) - 2) || !$past(base_tick)));
endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch
  import clksrc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic np_tick,
  input  logic pll_tick,
  input  logic af_tick,
  input  logic af_present,
  input  logic wfi_active,
  input  logic pll_sel,
  input  logic alt_sel,
  input  logic alt_wfi,
  input  logic lp_wfi,
  input  logic xt_stop,
  output logic alt_running,
  output logic int_tick,
  output logic xt_osc_en,
  output logic low_power,
  output logic ckaf_status
);
  localparam int CNT_W = $clog2(SYNC_N) + 1;

  sw_e              state_q;
  src_e             cur_q, nxt_q, target;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_tick, nxt_tick, want_alt;

  function automatic logic tick_of(input src_e s, input logic a, input logic b, input logic c);
    case (s)
      SRC_XT:  tick_of = a;
      SRC_PLL: tick_of = b;
      default: tick_of = c;
    endcase
  endfunction

  assign want_alt    = af_present && (alt_sel || (wfi_active && alt_wfi));
  assign target      = want_alt ? SRC_ALT : (pll_sel ? SRC_PLL : SRC_XT);
  assign cur_tick    = tick_of(cur_q, np_tick, pll_tick, af_tick);
  assign nxt_tick    = tick_of(nxt_q, np_tick, pll_tick, af_tick);
  assign alt_running = (state_q == SW_RUN) && (cur_q == SRC_ALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SW_RUN;
      cur_q       <= SRC_XT;
      nxt_q       <= SRC_XT;
      cnt_q       <= '0;
      int_tick    <= 1'b0;
      xt_osc_en   <= 1'b1;
      low_power   <= 1'b0;
      ckaf_status <= 1'b0;
    end else begin
      int_tick    <= (state_q == SW_RUN) && cur_tick;
      xt_osc_en   <= !(xt_stop && af_present && alt_running);
      low_power   <= wfi_active && lp_wfi;
      ckaf_status <= alt_running;
      case (state_q)
        SW_RUN: if (target != cur_q) state_q <= SW_DRAIN;
        SW_DRAIN: begin
          if (target == cur_q) begin
            state_q <= SW_RUN;
          end else if (cur_tick || (cur_q == SRC_ALT && !af_present)) begin
            state_q <= SW_SYNC;
            nxt_q   <= target;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (target != nxt_q) begin
            nxt_q <= target;
            cnt_q <= '0;
          end else if (nxt_tick) begin
            if (cnt_q == CNT_W'(SYNC_N - 1)) begin
              cur_q   <= nxt_q;
              state_q <= SW_RUN;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_sync_two_ticks_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == SW_SYNC && state_q == SW_RUN) |-> ($past(cnt_q) == CNT_W'(SYNC_N - 1) && $past(nxt_tick)));
  assert_xt_off_only_alt_R7: assert property (@(posedge clk) disable iff (rst)
    !xt_osc_en |-> ckaf_status);
  assert_lowp_follows_wfi_R8: assert property (@(posedge clk) disable iff (rst)
    low_power |-> $past(wfi_active));
  assert_alt_needs_present_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == SW_SYNC && state_q == SW_RUN && cur_q == SRC_ALT) |-> $past(af_present));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ACC_W  = 8,
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          xt_tick,
  input  logic          af_tick,
  input  logic          af_present,
  input  logic          wfi_active,
  output logic          int_tick,
  output logic          xt_osc_en,
  output logic          low_power,
  output logic          ckaf_status
);
  logic       half_sel, pll_sel, div16_sel, xt_stop, alt_sel, lp_wfi, alt_wfi;
  logic [1:0] mx;
  logic [2:0] dx;
  logic       np_tick, pll_tick, alt_running;

  clksrc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .alt_running(alt_running), .af_present(af_present),
    .half_sel(half_sel), .pll_sel(pll_sel), .div16_sel(div16_sel), .xt_stop(xt_stop),
    .alt_sel(alt_sel), .lp_wfi(lp_wfi), .alt_wfi(alt_wfi), .mx(mx), .dx(dx),
    .rdata(bus_rdata)
  );

  clksrc_paths #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_paths (
    .clk(clk), .rst(rst), .xt_tick(xt_tick), .half_sel(half_sel),
    .div16_sel(div16_sel), .mx(mx), .dx(dx), .np_tick(np_tick), .pll_tick(pll_tick)
  );

  clksrc_switch #(.SYNC_N(SYNC_N)) u_switch (
    .clk(clk), .rst(rst), .np_tick(np_tick), .pll_tick(pll_tick), .af_tick(af_tick),
    .af_present(af_present), .wfi_active(wfi_active), .pll_sel(pll_sel),
    .alt_sel(alt_sel), .alt_wfi(alt_wfi), .lp_wfi(lp_wfi), .xt_stop(xt_stop),
    .alt_running(alt_running), .int_tick(int_tick), .xt_osc_en(xt_osc_en),
    .low_power(low_power), .ckaf_status(ckaf_status)
  );
endmodule

// File: tb/clksrc_ctrl_bench.sv
module clksrc_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int XT_P  = 6;
  localparam int AF_P  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       xt_tick = 1'b0, af_tick = 1'b0, af_present = 1'b0, wfi_active = 1'b0;
  logic       int_tick, xt_osc_en, low_power, ckaf_status;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  clksrc_ctrl u_clksrc_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xt_tick(xt_tick), .af_tick(af_tick), .af_present(af_present),
    .wfi_active(wfi_active), .int_tick(int_tick), .xt_osc_en(xt_osc_en),
    .low_power(low_power), .ckaf_status(ckaf_status)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int r_mode, r_sel, r_ctl, r_pll;
  int half_ph, d16, acc, st, cur, nxt, cnt;
  int e_tick, e_xten, e_lowp, e_ckaf, e_rd;

  always @(posedge clk) begin : model
    int base, npt, pllt, m, n, tgt, ct, nt, run_alt, s;
    if (rst) begin
      r_mode = 0; r_sel = 0; r_ctl = 0; r_pll = 0;
      half_ph = 0; d16 = 0; acc = 0; st = 0; cur = 0; nxt = 0; cnt = 0;
      e_tick = 0; e_xten = 1; e_lowp = 0; e_ckaf = 0; e_rd = 0;
    end else begin
      base = (xt_tick && (!(r_mode & 1) || half_ph)) ? 1 : 0;
      npt  = (base && (!(r_sel & 2) || d16 == 15)) ? 1 : 0;
      case (r_pll & 3)
        0: m = 6; 1: m = 8; 2: m = 10; default: m = 14;
      endcase
      n    = ((r_pll >> 2) & 7) + 1;
      pllt = (acc >= n) ? 1 : 0;
      tgt  = (af_present && ((r_ctl & 1) || (wfi_active && (r_ctl & 4)))) ? 2 : (r_sel & 1);
      ct   = (cur == 0) ? npt : (cur == 1) ? pllt : int'(af_tick);
      nt   = (nxt == 0) ? npt : (nxt == 1) ? pllt : int'(af_tick);
      run_alt = (st == 0 && cur == 2) ? 1 : 0;
      case (bus_addr)
        2'd0: e_rd = r_mode;
        2'd1: e_rd = (run_alt << 7) | (int'(af_present) << 6) | r_sel;
        2'd2: e_rd = r_ctl;
        default: e_rd = r_pll;
      endcase
      e_tick = (st == 0 && ct) ? 1 : 0;
      e_xten = ((r_sel & 4) && af_present && run_alt) ? 0 : 1;
      e_lowp = (wfi_active && (r_ctl & 2)) ? 1 : 0;
      e_ckaf = run_alt;
      if (st == 0) begin
        if (tgt != cur) st = 1;
      end else if (st == 1) begin
        if (tgt == cur) st = 0;
        else if (ct || (cur == 2 && !af_present)) begin st = 2; nxt = tgt; cnt = 0; end
      end else begin
        if (tgt != nxt) begin nxt = tgt; cnt = 0; end
        else if (nt) begin
          if (cnt == 1) begin cur = nxt; st = 0; end
          else cnt = cnt + 1;
        end
      end
      if (xt_tick) half_ph = 1 - half_ph;
      if (base) d16 = (d16 + 1) % 16;
      s = acc + (base ? m : 0) - (pllt ? n : 0);
      acc = (s > 255) ? 255 : s;
      if (bus_we) begin
        case (bus_addr)
          2'd0: r_mode = int'(bus_wdata);
          2'd1: r_sel = int'(bus_wdata) & 63;
          2'd2: r_ctl = int'(bus_wdata);
          default: r_pll = int'(bus_wdata);
        endcase
      end
    end
  end

  // every-cycle comparison (R6 handover timing is covered here)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({"R6/", phase, " int_tick"}, int'(int_tick), e_tick);
      check({"R7/", phase, " xt_osc_en"}, int'(xt_osc_en), e_xten);
      check({"R8/", phase, " low_power"}, int'(low_power), e_lowp);
      check({"R5/", phase, " ckaf_status"}, int'(ckaf_status), e_ckaf);
      check({"R11/", phase, " rdata"}, int'(bus_rdata), e_rd);
    end
  end

  // crystal and alternate pulse sources
  int xt_cnt = 0, af_cnt = 0;
  always @(negedge clk) begin
    xt_cnt = (xt_cnt + 1) % XT_P;
    af_cnt = (af_cnt + 1) % AF_P;
    xt_tick <= (xt_cnt == 0) && xt_osc_en && !rst;
    af_tick <= (af_cnt == 0) && af_present;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    idle(2);
    check(tag, int'(bus_rdata), exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 int_tick", int'(int_tick), 0);
    check("R1 xt_osc_en", int'(xt_osc_en), 1);
    check("R1 low_power", int'(low_power), 0);
    check("R1 ckaf_status", int'(ckaf_status), 0);
    rd(2'd3, 0, "R1 pll reg");
    phase = "R3"; idle(200);
    phase = "R2"; wr(2'd0, 8'h01); idle(200);
    phase = "R3"; wr(2'd1, 8'h02); idle(700);
    phase = "R4"; wr(2'd3, 8'h0E); wr(2'd1, 8'h01); idle(400);
    wr(2'd3, 8'h19); idle(400);
    phase = "R5"; af_present = 1'b1; wr(2'd2, 8'h01); idle(300);
    check("R5 alt active", int'(ckaf_status), 1);
    rd(2'd1, 8'hC1, "R5 status readback");
    phase = "R7"; wr(2'd1, 8'h05); idle(50);
    check("R7 crystal stopped", int'(xt_osc_en), 0);
    af_present = 1'b0; idle(300);
    check("R7 crystal restarted", int'(xt_osc_en), 1);
    check("R5 alt lost", int'(ckaf_status), 0);
    phase = "R9"; wr(2'd2, 8'h06); af_present = 1'b1; idle(100);
    check("R9 no alt outside wait", int'(ckaf_status), 0);
    wfi_active = 1'b1; idle(300);
    check("R8 low power in wait", int'(low_power), 1);
    check("R9 alt in wait", int'(ckaf_status), 1);
    check("R7 crystal stopped in wait", int'(xt_osc_en), 0);
    phase = "R10"; wfi_active = 1'b0; idle(400);
    check("R10 low power off", int'(low_power), 0);
    check("R10 alt released", int'(ckaf_status), 0);
    check("R10 crystal on", int'(xt_osc_en), 1);
    phase = "R9"; af_present = 1'b0; wfi_active = 1'b1; idle(200);
    check("R9 absent alt ignored", int'(ckaf_status), 0);
    check("R8 low power absent alt", int'(low_power), 1);
    wfi_active = 1'b0; idle(50);
    phase = "R11"; wr(2'd0, 8'h81);
    rd(2'd0, 8'h81, "R11 mode readback");
    rd(2'd1, 8'h05, "R11 select readback");
    rd(2'd2, 8'h06, "R11 control readback");
    rd(2'd3, 8'h19, "R11 pll readback");
    idle(100);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule